// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This combinational unit adds or subtracts two integers stored in sign-magnitude form. The top bit of each operand is the sign and the remaining bits are an unsigned magnitude. The result comes from comparing signs and magnitudes rather than from a single two's-complement sum. Operands with the same effective sign have their magnitudes added. Operands with opposite signs have their magnitudes subtracted, and the result takes the sign of the operand with the larger magnitude.

A subtract select flips the sign of the second operand before the sign analysis. Both encodings of zero are accepted on the inputs. A zero result always leaves as positive zero.

Two auxiliary outputs derive from the first operand:
- its negation, in which only the sign bit changes;
- a double-width copy, in which the sign moves to the new top bit and the added magnitude bits are zero.

With the default width of 8, bit 7 is the sign, bits 6..0 are the magnitude, and the widened copy is 16 bits.

Top module: `sm_addsub`

## Requirements
- R1: With `sub_i`=0 and equal operand signs (bit 7, 1 = negative; bits 6..0 = magnitude), `sum_o` magnitude is the sum of the magnitudes, and the sign is the common sign whenever the magnitude is nonzero.
- R2: With unequal effective signs, `sum_o` magnitude is the absolute difference of the magnitudes, and the sign is that of the operand with the larger magnitude. For example, 0x99 (-25) plus 0x0D (+13) gives 0x8C (-12).
- R3: `ovf_o` is 1 exactly when the effective signs match and the magnitude sum exceeds 127. The result magnitude is then the low 7 bits of that sum. `ovf_o` is never 1 when the effective signs differ.
- R4: 0x00 and 0x80 both act as zero operands. A result whose magnitude is zero is output as 0x00, and `zero_o` is 1 exactly in that case.
- R5: `sub_i`=1 gives a minus b, computed as a plus b with b's bit 7 inverted. For example, 0x0D minus 0x19 gives 0x8C.
- R6: `neg_o` equals `a_i` with bit 7 inverted and bits 6..0 unchanged.
- R7: `wide_o[15]` equals `a_i[7]`, `wide_o[14:7]` is zero, and `wide_o[6:0]` equals `a_i[6:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand, sign-magnitude |
| b_i | input | 8 | Second operand, sign-magnitude |
| sub_i | input | 1 | 1 selects a minus b, 0 selects a plus b |
| sum_o | output | 8 | Sign-magnitude result |
| ovf_o | output | 1 | Magnitude overflow on like-signed addition |
| zero_o | output | 1 | Result magnitude is zero |
| neg_o | output | 8 | Negated first operand |
| wide_o | output | 16 | First operand widened to 16 bits |

## Verification
The block holds no state, so any fault shows on the ports in the same evaluation as the inputs that expose it.

A wrong borrow decision in the magnitude subtraction shows as a flipped sign or a two's-complement-looking magnitude. This appears only on opposite-sign pairs whose magnitudes are ordered the wrong way. A missed sign fix-up for zero appears only as 0x80 on cancelling inputs.

Random pairs must therefore be mixed with cancelling pairs, equal-magnitude pairs, negative-zero operands and sums that land exactly on 128.

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sub_i,
  output logic [W-1:0]   sum_o,
  output logic           ovf_o,
  output logic           zero_o,
  output logic [W-1:0]   neg_o,
  output logic [2*W-1:0] wide_o
);
  localparam int MW = W - 1;
  localparam int WW = 2 * W;

  logic          sa, sb, same, sgn;
  logic [MW-1:0] ma, mb, dneg, mag;
  logic [MW:0]   sum, dif;

  assign sa   = a_i[W-1];
  assign sb   = b_i[W-1] ^ sub_i;
  assign ma   = a_i[MW-1:0];
  assign mb   = b_i[MW-1:0];
  assign same = (sa == sb);

  assign sum  = {1'b0, ma} + {1'b0, mb};
  assign dif  = {1'b0, ma} + {1'b0, ~mb} + {{MW{1'b0}}, 1'b1};
  assign dneg = ~dif[MW-1:0] + {{(MW-1){1'b0}}, 1'b1};

  assign mag  = same ? sum[MW-1:0] : (dif[MW] ? dif[MW-1:0] : dneg);
  assign sgn  = same ? sa : (dif[MW] ? sa : sb);

  assign zero_o = (mag == '0);
  assign sum_o  = {sgn & ~zero_o, mag};
  assign ovf_o  = same & sum[MW];
  assign neg_o  = {~a_i[W-1], a_i[MW-1:0]};
  assign wide_o = {a_i[W-1], {W{1'b0}}, a_i[MW-1:0]};

  always_comb begin
    AST_SAME_SIGN: assert (!((a_i[W-1] == (b_i[W-1] ^ sub_i)) && sum_o[MW-1:0] != '0) || sum_o[W-1] == a_i[W-1]) else $error("sign mismatch"); // R1
    AST_DIFF_BOUND: assert ((a_i[W-1] == (b_i[W-1] ^ sub_i)) || (sum_o[MW-1:0] <= ((ma > mb) ? ma : mb))) else $error("difference too large"); // R2
    AST_NO_OVERFLOW: assert (!(ovf_o && (a_i[W-1] != (b_i[W-1] ^ sub_i)))) else $error("overflow on unlike signs"); // R3
    AST_ZERO_POS: assert (!zero_o || sum_o == '0) else $error("negative zero out"); // R4
    AST_NEG_MAG: assert (neg_o[MW-1:0] == a_i[MW-1:0] && neg_o[W-1] != a_i[W-1]) else $error("negation"); // R6
    AST_WIDE_FILL: assert (wide_o[WW-2:MW] == '0 && wide_o[WW-1] == a_i[W-1]) else $error("widening"); // R7
  end
endmodule

// File: tb/sm_addsub_test.sv
`timescale 1ns/1ps
module sm_addsub_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  a, b;
  logic        sub;
  logic [7:0]  sum, neg;
  logic        ovf, zero;
  logic [15:0] wide;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  sm_addsub uut (
    .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum), .ovf_o(ovf), .zero_o(zero),
    .neg_o(neg), .wide_o(wide)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h sub=%0d actual=%h expected=%h", tag, a, b, sub, act, exp);
    end
  endtask

  function automatic int smval(input logic [7:0] v);
    return v[7] ? -int'(v[6:0]) : int'(v[6:0]);
  endfunction

  task automatic run(input logic [7:0] ai, input logic [7:0] bi, input logic si, input string extra);
    int va, vb, r, ar, rm;
    logic [7:0] er;
    logic eo, ez;
    string tag;
    @(posedge clk);
    a = ai; b = bi; sub = si;
    @(negedge clk);
    va = smval(ai);
    vb = si ? -smval(bi) : smval(bi);
    r  = va + vb;
    ar = (r < 0) ? -r : r;
    rm = ar % 128;
    eo = (ar > 127);
    ez = (rm == 0);
    er = {(r < 0) && !ez, rm[6:0]};
    if (eo) tag = "R3";
    else if (ez) tag = "R4";
    else if ((ai[7] == (bi[7] ^ si))) tag = "R1";
    else tag = "R2";
    if (extra != "") tag = extra;
    chk(tag, {8'h0, sum}, {8'h0, er});
    chk("R3", {15'h0, ovf}, {15'h0, eo});
    chk("R4", {15'h0, zero}, {15'h0, ez});
    chk("R6", {8'h0, neg}, {8'h0, ~ai[7], ai[6:0]});
    chk("R7", wide, {ai[7], 8'h00, ai[6:0]});
  endtask

  initial begin
    a = 8'h00; b = 8'h00; sub = 1'b0;
    @(negedge clk);
    chk("R4", {8'h0, sum}, 16'h0000);
    chk("R4", {15'h0, zero}, 16'h0001);
    run(8'h99, 8'h0D, 1'b0, "R2");
    run(8'h0D, 8'h99, 1'b0, "R2");
    run(8'h19, 8'h0D, 1'b0, "R1");
    run(8'h99, 8'h8D, 1'b0, "R1");
    run(8'h0D, 8'h19, 1'b1, "R5");
    run(8'h99, 8'h0D, 1'b1, "R5");
    run(8'h80, 8'h00, 1'b0, "R4");
    run(8'h80, 8'h80, 1'b0, "R4");
    run(8'h80, 8'h80, 1'b1, "R4");
    run(8'h25, 8'hA5, 1'b0, "R4");
    run(8'h25, 8'h25, 1'b1, "R4");
    run(8'h7F, 8'h01, 1'b0, "R3");
    run(8'h7F, 8'h7F, 1'b0, "R3");
    run(8'hFF, 8'hFF, 1'b0, "R3");
    run(8'hFF, 8'h7F, 1'b1, "R3");
    run(8'h7F, 8'hFF, 1'b0, "R2");
    run(8'h00, 8'h81, 1'b0, "R2");
    void'($urandom(32'd417));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (i % 7 == 0) rb = {~ra[7], ra[6:0]};
      if (i % 11 == 0) ra = {ra[7], 7'h00};
      run(ra, rb, 1'($urandom), "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule